// File: doc/BRIEF.md
# DDR Output Register Stage with Output Enable

This block sits between core logic and an output or bidirectional pin buffer. It takes a data bus and an output-enable request from the core. It produces the level for each pin and a per-bit drive enable for the tri-state buffer. A set of parameters selects how the data reaches the pin. In bypass mode the data passes through as a wire. In single-rate mode one register is clocked on the rising edge. In double-rate mode two words are captured on each rising edge and the pin shows them one after the other, one in each half of the clock.

The enable path has three forms of its own. It can pass straight through, go through one rising-edge register, or go through a rising-edge and falling-edge register pair. Further options complement the data and switch the pin to open-drain signalling. In double-rate mode the design can also have an asynchronous clear, an asynchronous preset and a clock enable for the launch registers. The parameter checks stop elaboration for illegal combinations: asynchronous ports or the register-pair enable outside double-rate mode, and a registered enable in bypass mode.

Top module: `pin_out_stage`

## Requirements
- R1: In bypass mode with a direct enable, `pin_dout` equals `data_hi` (after any inversion) and every bit of `pin_en` equals `oe_req` within the same cycle. A `pin_en` bit of 1 means the pin is driven; 0 means high impedance.
- R2: In single-rate mode, `data_hi` is captured on a rising edge where the launch is enabled. The captured word is held on `pin_dout` for the whole following cycle.
- R3: In double-rate mode, `data_hi` and `data_lo` are captured together on one rising edge. In the following cycle the pin shows the `data_hi` word while `clk` is high and the `data_lo` word while `clk` is low.
- R4: When the clock-enable option is on, `clk_en` low at a rising edge makes the data and enable registers keep their values. When the option is off, `clk_en` has no effect.
- R5: With inversion on, every data bit is complemented before it reaches the pin.
- R6: With open drain on, `pin_dout` is always 0. A bit is driven only while the enable is active and that bit's level is 0.
- R7: With a single-register enable, `pin_en` takes the `oe_req` value captured at a launching rising edge and holds it for the full cycle.
- R8: With the register-pair enable, a captured 0 turns the pin off at that rising edge. A captured 1 after a 0 turns it on only at the next falling edge, so the pin is high impedance during the high-phase word of that cycle.
- R9: With the clear option on, `aclr` high at once forces the data registers to 0 and the enable registers off. All pins are then released until a rising edge after `aclr` falls.
- R10: With the preset option on, `aset` high at once forces the data registers to all ones and the enable registers off. With open drain this releases every pin.
- R11: When the clear or preset option is off, the matching input has no effect on either output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Launch clock; both edges are used in double-rate mode |
| clk_en | input | 1 | Launch enable for the rising-edge registers |
| aclr | input | 1 | Asynchronous clear, active high |
| aset | input | 1 | Asynchronous preset, active high |
| data_hi | input | WIDTH | Word shown in the high phase (the only word outside double-rate mode) |
| data_lo | input | WIDTH | Word shown in the low phase in double-rate mode |
| oe_req | input | 1 | Output-enable request from the core |
| pin_dout | output | WIDTH | Level presented to the pin buffer |
| pin_en | output | WIDTH | Per-bit drive enable; 0 is high impedance |

## Verification
On every rising edge the assertions check these rules:
- the single-rate capture and the double-rate low-phase word;
- holding while the launch is disabled;
- the enable register following the request;
- the forced levels under an asynchronous port.

A falling-edge assertion checks that a newly set enable register leaves the high phase undriven.

Some behaviours appear only through the scenarios:
- the high-phase word on the pin;
- inversion combined with open drain;
- a clock enable that is configured away;
- asynchronous inputs of disabled options leaving the pin alone;
- the bypass path.

// File: rtl/pin_out_pkg.sv
`timescale 1ns/100ps
package pin_out_pkg;
   // how the data word travels to the pin
   typedef enum logic [1:0] {
      REG_BYPASS = 2'd0,
      REG_SDR    = 2'd1,
      REG_DDR    = 2'd2
   } reg_mode_e;

   // how the output enable travels to the buffer
   typedef enum logic [1:0] {
      OE_DIRECT = 2'd0,
      OE_SINGLE = 2'd1,
      OE_DOUBLE = 2'd2
   } oe_mode_e;
endpackage

// File: rtl/pin_data_regs.sv
`timescale 1ns/100ps
module pin_data_regs
   import pin_out_pkg::*;
#(
   parameter int        WIDTH  = 8,
   parameter reg_mode_e MODE   = REG_DDR,
   parameter bit        INVERT = 1'b0
) (
   input  logic             clk,
   input  logic             cen,
   input  logic             arst,
   input  logic             arst_high,
   input  logic [WIDTH-1:0] word_hi_i,
   input  logic [WIDTH-1:0] word_lo_i,
   output logic [WIDTH-1:0] level_o
);
   localparam logic [WIDTH-1:0] FLIP_MASK = INVERT ? {WIDTH{1'b1}} : {WIDTH{1'b0}};

   logic [WIDTH-1:0] hi_w;
   logic [WIDTH-1:0] lo_w;

   // complement ahead of the registers so forced levels are pin levels
   assign hi_w = word_hi_i ^ FLIP_MASK;
   assign lo_w = word_lo_i ^ FLIP_MASK;

   generate
      if (MODE == REG_BYPASS) begin : g_wire
         assign level_o = hi_w;
         logic unused_wire;
         assign unused_wire = ^{clk, cen, arst, arst_high, lo_w};
      end else if (MODE == REG_SDR) begin : g_single
         logic [WIDTH-1:0] word_q;

         always_ff @(posedge clk or posedge arst) begin
            if (arst)     word_q <= {WIDTH{arst_high}};
            else if (cen) word_q <= hi_w;
         end

         assign level_o = word_q;
         logic unused_single;
         assign unused_single = ^lo_w;

         // R2
         sdr_capture_chk: assert property (@(posedge clk) disable iff (arst)
            cen |=> (level_o == $past(hi_w)));
      end else begin : g_double
         logic [WIDTH-1:0] hi_q;
         logic [WIDTH-1:0] lo_q;
         logic [WIDTH-1:0] lo_fall_q;

         always_ff @(posedge clk or posedge arst) begin
            if (arst) begin
               hi_q <= {WIDTH{arst_high}};
               lo_q <= {WIDTH{arst_high}};
            end else if (cen) begin
               hi_q <= hi_w;
               lo_q <= lo_w;
            end
         end

         // low word crosses to the falling edge so the mux input is settled
         always_ff @(negedge clk or posedge arst) begin
            if (arst) lo_fall_q <= {WIDTH{arst_high}};
            else      lo_fall_q <= lo_q;
         end

         assign level_o = clk ? hi_q : lo_fall_q;

         // R3
         ddr_low_word_chk: assert property (@(posedge clk) disable iff (arst)
            cen |=> (level_o == $past(lo_w)));
         // R4
         ddr_hold_chk: assert property (@(posedge clk) disable iff (arst)
            !cen |=> (level_o == $past(level_o)));
         // R9 R10
         async_level_chk: assert property (@(posedge clk)
            arst |-> (level_o == {WIDTH{arst_high}}));
      end
   endgenerate
endmodule

// File: rtl/pin_oe_regs.sv
`timescale 1ns/100ps
module pin_oe_regs
   import pin_out_pkg::*;
#(
   parameter oe_mode_e MODE = OE_DOUBLE
) (
   input  logic clk,
   input  logic cen,
   input  logic arst,
   input  logic oe_i,
   output logic en_o
);
   generate
      if (MODE == OE_DIRECT) begin : g_direct
         assign en_o = oe_i;
         logic unused_direct;
         assign unused_direct = ^{clk, cen, arst};
      end else if (MODE == OE_SINGLE) begin : g_single
         logic oe_q;

         always_ff @(posedge clk or posedge arst) begin
            if (arst)     oe_q <= 1'b0;
            else if (cen) oe_q <= oe_i;
         end

         assign en_o = oe_q;

         // R7
         oe_single_follow_chk: assert property (@(posedge clk) disable iff (arst)
            cen |=> (en_o == $past(oe_i)));
      end else begin : g_pair
         logic oe_rise_q;
         logic oe_fall_q;

         always_ff @(posedge clk or posedge arst) begin
            if (arst)     oe_rise_q <= 1'b0;
            else if (cen) oe_rise_q <= oe_i;
         end

         always_ff @(negedge clk or posedge arst) begin
            if (arst) oe_fall_q <= 1'b0;
            else      oe_fall_q <= oe_rise_q;
         end

         // off at the rising edge, on only after the falling stage agrees
         assign en_o = oe_rise_q & oe_fall_q;

         // R8
         oe_pair_follow_chk: assert property (@(posedge clk) disable iff (arst)
            cen |=> (en_o == $past(oe_i)));
         // R8
         oe_late_turn_on_chk: assert property (@(negedge clk) disable iff (arst)
            $rose(oe_rise_q) |-> !en_o);
      end
   endgenerate
endmodule

// File: rtl/pin_drive.sv
`timescale 1ns/100ps
module pin_drive #(
   parameter int WIDTH      = 8,
   parameter bit OPEN_DRAIN = 1'b0
) (
   input  logic [WIDTH-1:0] level_i,
   input  logic             en_i,
   output logic [WIDTH-1:0] dout_o,
   output logic [WIDTH-1:0] pen_o
);
   generate
      if (OPEN_DRAIN) begin : g_od
         // a one is signalled by releasing the pin, never by driving it
         assign dout_o = {WIDTH{1'b0}};
         assign pen_o  = {WIDTH{en_i}} & ~level_i;
      end else begin : g_push
         assign dout_o = level_i;
         assign pen_o  = {WIDTH{en_i}};
      end
   endgenerate
endmodule

// File: rtl/pin_out_stage.sv
`timescale 1ns/100ps
module pin_out_stage
   import pin_out_pkg::*;
#(
   parameter int        WIDTH      = 8,
   parameter reg_mode_e REG_MODE   = REG_DDR,
   parameter oe_mode_e  OE_MODE    = OE_DOUBLE,
   parameter bit        INVERT     = 1'b0,
   parameter bit        OPEN_DRAIN = 1'b0,
   parameter bit        USE_CLK_EN = 1'b1,
   parameter bit        USE_ACLR   = 1'b1,
   parameter bit        USE_ASET   = 1'b0
) (
   input  logic             clk,
   input  logic             clk_en,
   input  logic             aclr,
   input  logic             aset,
   input  logic [WIDTH-1:0] data_hi,
   input  logic [WIDTH-1:0] data_lo,
   input  logic             oe_req,
   output logic [WIDTH-1:0] pin_dout,
   output logic [WIDTH-1:0] pin_en
);
   localparam bit ASYNC_USED = USE_ACLR || USE_ASET;

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("pin_out_stage: WIDTH must be at least 1");
      end
      if (ASYNC_USED && (REG_MODE != REG_DDR)) begin : g_bad_async
         $error("pin_out_stage: asynchronous clear/preset need double-rate mode");
      end
      if ((OE_MODE == OE_DOUBLE) && (REG_MODE != REG_DDR)) begin : g_bad_oe_pair
         $error("pin_out_stage: register-pair enable needs double-rate mode");
      end
      if ((OE_MODE == OE_SINGLE) && (REG_MODE == REG_BYPASS)) begin : g_bad_oe_reg
         $error("pin_out_stage: registered enable needs a registered data path");
      end
   endgenerate

   logic             cen;
   logic             clr_on;
   logic             set_on;
   logic             arst;
   logic             arst_high;
   logic [WIDTH-1:0] level;
   logic             en;

   assign cen       = USE_CLK_EN ? clk_en : 1'b1;
   assign clr_on    = USE_ACLR & aclr;
   assign set_on    = USE_ASET & aset;
   assign arst      = clr_on | set_on;
   // clear wins when both are asserted
   assign arst_high = set_on & ~clr_on;

   pin_data_regs #(
      .WIDTH (WIDTH),
      .MODE  (REG_MODE),
      .INVERT(INVERT)
   ) u_data (
      .clk      (clk),
      .cen      (cen),
      .arst     (arst),
      .arst_high(arst_high),
      .word_hi_i(data_hi),
      .word_lo_i(data_lo),
      .level_o  (level)
   );

   pin_oe_regs #(
      .MODE(OE_MODE)
   ) u_oe (
      .clk (clk),
      .cen (cen),
      .arst(arst),
      .oe_i(oe_req),
      .en_o(en)
   );

   pin_drive #(
      .WIDTH     (WIDTH),
      .OPEN_DRAIN(OPEN_DRAIN)
   ) u_drive (
      .level_i(level),
      .en_i   (en),
      .dout_o (pin_dout),
      .pen_o  (pin_en)
   );
endmodule

// File: tb/pin_out_stage_test.sv
`timescale 1ns/100ps
module pin_out_stage_test;
   import pin_out_pkg::*;

   logic       clk = 1'b0;
   logic       clk_en = 1'b1;
   logic       aclr = 1'b0;
   logic       aset = 1'b0;
   logic [7:0] data_hi = 8'h00;
   logic [7:0] data_lo = 8'h00;
   logic       oe_req = 1'b0;

   logic [7:0] a_dout, a_en, o_dout, o_en, s_dout, s_en, b_dout, b_en;

   int  n_checks = 0;
   int  n_fail = 0;
   int  cyc = 0;
   bit  done = 1'b0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   // DDR, register-pair enable, clock enable, clear
   pin_out_stage #(.WIDTH(8), .REG_MODE(REG_DDR), .OE_MODE(OE_DOUBLE), .INVERT(1'b0),
      .OPEN_DRAIN(1'b0), .USE_CLK_EN(1'b1), .USE_ACLR(1'b1), .USE_ASET(1'b0)) uut (
      .clk(clk), .clk_en(clk_en), .aclr(aclr), .aset(aset), .data_hi(data_hi),
      .data_lo(data_lo), .oe_req(oe_req), .pin_dout(a_dout), .pin_en(a_en));

   // DDR, direct enable, inverted open drain, preset, no clock enable
   pin_out_stage #(.WIDTH(8), .REG_MODE(REG_DDR), .OE_MODE(OE_DIRECT), .INVERT(1'b1),
      .OPEN_DRAIN(1'b1), .USE_CLK_EN(1'b0), .USE_ACLR(1'b0), .USE_ASET(1'b1)) uut_od (
      .clk(clk), .clk_en(clk_en), .aclr(aclr), .aset(aset), .data_hi(data_hi),
      .data_lo(data_lo), .oe_req(oe_req), .pin_dout(o_dout), .pin_en(o_en));

   // SDR, single-register enable
   pin_out_stage #(.WIDTH(8), .REG_MODE(REG_SDR), .OE_MODE(OE_SINGLE), .INVERT(1'b0),
      .OPEN_DRAIN(1'b0), .USE_CLK_EN(1'b1), .USE_ACLR(1'b0), .USE_ASET(1'b0)) uut_sdr (
      .clk(clk), .clk_en(clk_en), .aclr(aclr), .aset(aset), .data_hi(data_hi),
      .data_lo(data_lo), .oe_req(oe_req), .pin_dout(s_dout), .pin_en(s_en));

   // bypass, direct enable
   pin_out_stage #(.WIDTH(8), .REG_MODE(REG_BYPASS), .OE_MODE(OE_DIRECT), .INVERT(1'b0),
      .OPEN_DRAIN(1'b0), .USE_CLK_EN(1'b0), .USE_ACLR(1'b0), .USE_ASET(1'b0)) uut_byp (
      .clk(clk), .clk_en(clk_en), .aclr(aclr), .aset(aset), .data_hi(data_hi),
      .data_lo(data_lo), .oe_req(oe_req), .pin_dout(b_dout), .pin_en(b_en));

   typedef struct {
      int         due;
      logic [7:0] dh, dl;
      logic       eh, el;
      logic [7:0] oh, ol;
      logic [7:0] sd;
      logic       se;
   } exp_t;

   exp_t sb[$];
   exp_t cur;

   // bench model of the registered state
   logic [7:0] m_hi, m_lo, m_oh, m_ol, m_sd;
   logic       m_oe, m_se;

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic drive(input logic [7:0] h, input logic [7:0] l, input logic oe, input logic c);
      exp_t e;
      logic prev;
      @(posedge clk);
      #1;
      data_hi = h; data_lo = l; oe_req = oe; clk_en = c;
      prev = m_oe;
      if (c) begin
         m_hi = h; m_lo = l; m_oe = oe; m_sd = h; m_se = oe;
      end
      m_oh = ~h; m_ol = ~l;
      e.due = cyc + 1;
      e.dh = m_hi; e.dl = m_lo; e.eh = m_oe & prev; e.el = m_oe;
      e.oh = m_oh; e.ol = m_ol; e.sd = m_sd; e.se = m_se;
      sb.push_back(e);
      #0.5;
      chk("R1 bypass enable", b_en, {8{oe}});
      chk("R1 bypass data", b_dout, h);
   endtask

   // monitor: pops one expected item per cycle and compares both phases
   initial begin : monitor
      forever begin
         @(posedge clk);
         #2;
         if (sb.size() > 0 && sb[0].due == cyc) begin
            cur = sb.pop_front();
            chk("R8 R4 high-phase enable", a_en, {8{cur.eh}});
            if (cur.eh) chk("R3 R4 high-phase word", a_dout, cur.dh);
            chk("R5 R6 R4 open-drain enable high", o_en, {8{oe_req}} & ~cur.oh);
            chk("R6 open-drain data high", o_dout, 8'h00);
            chk("R7 R4 sdr enable high", s_en, {8{cur.se}});
            if (cur.se) chk("R2 R4 sdr word high", s_dout, cur.sd);
            #2.5;
            chk("R8 R4 low-phase enable", a_en, {8{cur.el}});
            if (cur.el) chk("R3 R4 low-phase word", a_dout, cur.dl);
            chk("R5 R6 R4 open-drain enable low", o_en, {8{oe_req}} & ~cur.ol);
            chk("R6 open-drain data low", o_dout, 8'h00);
            chk("R7 sdr enable low", s_en, {8{cur.se}});
            if (cur.se) chk("R2 sdr word low", s_dout, cur.sd);
         end
      end
   end

   initial begin : watchdog
      #750000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog all requirements actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   initial begin : stimulus
      logic [15:0] lfsr;
      #1;
      aclr = 1'b1; aset = 1'b1; oe_req = 1'b1; clk_en = 1'b1;
      repeat (2) @(posedge clk);
      #1.5;
      chk("R9 reset clear releases pins", a_en, 8'h00);
      chk("R10 reset preset releases open drain", o_en, 8'h00);
      @(posedge clk); #1; oe_req = 1'b0;
      @(posedge clk); #1; aclr = 1'b0; aset = 1'b0;
      m_hi = 8'h00; m_lo = 8'h00; m_oe = 1'b0; m_sd = 8'h00; m_se = 1'b0;
      m_oh = 8'hFF; m_ol = 8'hFF;

      drive(8'hA5, 8'h3C, 1'b1, 1'b1);   // enable rises: high phase undriven
      drive(8'h96, 8'h69, 1'b1, 1'b1);
      drive(8'hFF, 8'h00, 1'b0, 1'b1);   // enable falls at the rising edge
      drive(8'h00, 8'hFF, 1'b1, 1'b1);
      drive(8'h81, 8'h7E, 1'b1, 1'b1);
      drive(8'h12, 8'h34, 1'b1, 1'b0);   // hold
      drive(8'h11, 8'h22, 1'b0, 1'b0);   // hold keeps enable on
      drive(8'h9A, 8'hBC, 1'b1, 1'b1);

      lfsr = 16'hACE1;
      for (int i = 0; i < 24; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         drive(lfsr[7:0], lfsr[15:8], (i % 5) != 2, (i % 6) != 4);
      end

      // settle on a steady pattern for the asynchronous checks
      repeat (3) drive(8'hC3, 8'h5A, 1'b1, 1'b1);
      repeat (2) @(posedge clk);

      @(posedge clk); #1; aset = 1'b1; #0.5;
      chk("R11 preset ignored by clear-only stage enable", a_en, 8'hFF);
      chk("R11 preset ignored by clear-only stage word", a_dout, 8'hC3);
      chk("R10 preset releases open-drain pins high", o_en, 8'h00);
      #2.5;
      chk("R10 preset releases open-drain pins low", o_en, 8'h00);
      chk("R11 preset ignored low word", a_dout, 8'h5A);
      @(posedge clk); #1; aset = 1'b0;
      @(posedge clk); #1.5;
      chk("R10 open drain resumes after preset", o_en, 8'hC3);

      @(posedge clk); #1; aclr = 1'b1; #0.5;
      chk("R9 clear releases pins at once", a_en, 8'h00);
      chk("R11 clear ignored by preset-only stage", o_en, 8'hC3);
      chk("R11 clear ignored by sdr enable", s_en, 8'hFF);
      chk("R11 clear ignored by sdr word", s_dout, 8'hC3);
      #2.5;
      chk("R9 clear holds pins released", a_en, 8'h00);
      chk("R11 clear ignored low phase", o_en, 8'h5A);
      @(posedge clk); #1; aclr = 1'b0;
      @(posedge clk); #2;
      chk("R8 enable after clear waits half cycle", a_en, 8'h00);
      #2.5;
      chk("R8 enable after clear on in low phase", a_en, 8'hFF);
      chk("R3 low word after clear", a_dout, 8'h5A);

      m_hi = 8'hC3; m_lo = 8'h5A; m_oe = 1'b1; m_sd = 8'hC3; m_se = 1'b1;
      drive(8'h0F, 8'hF0, 1'b1, 1'b1);
      drive(8'h33, 8'hCC, 1'b0, 1'b0);
      drive(8'h55, 8'hAA, 1'b0, 1'b1);
      drive(8'h66, 8'h99, 1'b1, 1'b1);
      repeat (3) @(posedge clk);
      #4;

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end
endmodule